// File: doc/BRIEF.md
# Frame-Aligned Connection Memory Sequencer

This block holds a table of 2048 words, each 16 bits wide, and plays it out one word at a time on its output bus. The read address comes from an internal 11-bit counter, and a frame pulse forces that counter back to zero. A host write port loads or changes table entries while the playout runs. A switching fabric uses the block as its per-channel connection store.

A two-bit mode input sets how the counter moves and how the table is used:

- **Half-rate:** the counter steps once every two clocks, so each word is shown for two clocks.
- **Full-rate:** the counter steps on every clock.
- **Streaming:** the counter's value is both the read address and the write address. Each clock, the word at that address is read out and then replaced with the word on the streaming input. The table becomes a delay line exactly one counter cycle long.

The output word is registered, so it follows the counter by one clock.

Top module: `cm_sequencer`

## Requirements
- R1: A synchronous active-high reset clears the output word to 0 and points the counter at address 0, so the first word read after reset is word 0.
- R2: With mode = 2'd0 (half-rate), the counter advances once every second clock, and each stored word stays on the output for two consecutive clocks.
- R3: With mode = 2'd1 (full-rate), the counter advances on every clock and wraps from 2047 to 0, so a new word appears on every clock.
- R4: A frame pulse sampled at a clock edge sets the next counter value to 0 in every mode, and also restarts the half-rate step phase.
- R5: With mode = 2'd2 (streaming), every clock writes the streaming input word into the location at the current counter value.
- R6: In streaming mode the location is read before it is overwritten, so the output equals the input from exactly 2048 clocks earlier, as long as no frame pulse intervenes.
- R7: In modes 2'd0, 2'd1 and 2'd3, a clock with the host write enable high stores the host data at the host address.
- R8: When a host write and the sequential read address hit the same location at the same edge, the output shows the old contents; the new word appears on the next visit.
- R9: In streaming mode the host write port has no effect on the table.
- R10: Mode 2'd3 sequences exactly like full-rate mode.
- R11: The output presents the word at the counter address of the previous edge, so it lags the counter by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_p | input | 1 | Frame pulse; restarts the counter at 0 |
| mode | input | 2 | 0 half-rate, 1 full-rate, 2 streaming, 3 same as full-rate |
| host_we | input | 1 | Host write enable (ignored in streaming mode) |
| host_addr | input | 11 | Host write address |
| host_wdata | input | 16 | Host write data |
| stream_din | input | 16 | Streaming input word, used in streaming mode |
| dout | output | 16 | Sequenced output word |

## Verification
The assertions check three counter rules on every cycle:
- the counter is zero after any frame pulse;
- it steps by exactly one outside half-rate mode;
- it never moves by more than one step in half-rate mode.

They also check that each host or streaming write lands at the address it targeted.

Some behaviours are only visible over whole scenarios, through the bench's reference model:
- the two-clock dwell of each word in half-rate mode;
- the read-before-write result when a host write collides with the read address;
- the full 2048-clock delay in streaming mode;
- host writes leaving no trace in the table during streaming, confirmed by reading the table back afterwards.

// File: rtl/cmseq_pkg.sv
package cmseq_pkg;

   typedef enum logic [1:0] {
      MODE_HALF   = 2'd0,
      MODE_FULL   = 2'd1,
      MODE_STREAM = 2'd2,
      MODE_ALT    = 2'd3
   } cm_mode_e;

   function automatic logic mode_is_stream(input cm_mode_e m);
      return m == MODE_STREAM;
   endfunction

endpackage

// File: rtl/cm_addr_seq.sv
module cm_addr_seq
   import cmseq_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter int HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frame_p,
   input  cm_mode_e          mode,
   output logic [ADDR_W-1:0] addr
);

   localparam int PH_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   initial begin : chk_params
      if (ADDR_W < 1)   $fatal(1, "cm_addr_seq: ADDR_W must be positive");
      if (HALF_DIV < 1) $fatal(1, "cm_addr_seq: HALF_DIV must be positive");
   end

   logic half_adv;
   logic adv;

   generate
      if (HALF_DIV == 1) begin : g_no_phase
         assign half_adv = 1'b1;
      end else begin : g_phase
         localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_DIV - 1);
         logic [PH_W-1:0] phase;

         always_ff @(posedge clk) begin
            if (rst || frame_p || mode != MODE_HALF)
               phase <= '0;
            else if (phase == PH_LAST)
               phase <= '0;
            else
               phase <= phase + 1'b1;
         end

         assign half_adv = (phase == PH_LAST);
      end
   endgenerate

   assign adv = (mode == MODE_HALF) ? half_adv : 1'b1;

   always_ff @(posedge clk) begin
      if (rst || frame_p)
         addr <= '0;
      else if (adv)
         addr <= addr + 1'b1;
   end

   // R4: a sampled frame pulse leaves the counter at zero
   assert_frame_zero_R4 : assert property (@(posedge clk) disable iff (rst)
      frame_p |=> addr == '0);

   // R3 / R10 / R5: outside half-rate the counter steps by exactly one
   assert_step_R3 : assert property (@(posedge clk) disable iff (rst)
      (mode != MODE_HALF && !frame_p) |=> addr == ADDR_W'($past(addr) + 1'b1));

   // R2: in half-rate the counter holds or moves by one, never more
   assert_half_step_R2 : assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_HALF && !frame_p) |=>
         (addr == $past(addr) || addr == ADDR_W'($past(addr) + 1'b1)));

endmodule

// File: rtl/cm_store.sv
module cm_store #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stream_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] stream_din,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] dout
);

   localparam int DEPTH = 1 << ADDR_W;

   initial begin : chk_params
      if (DATA_W < 1) $fatal(1, "cm_store: DATA_W must be positive");
      if (ADDR_W < 1) $fatal(1, "cm_store: ADDR_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic              we;
   logic [ADDR_W-1:0] waddr;
   logic [DATA_W-1:0] wdata;

   // In streaming mode the counter owns the write port and the host is shut out.
   always_comb begin
      if (stream_en) begin
         we    = 1'b1;
         waddr = rd_addr;
         wdata = stream_din;
      end else begin
         we    = host_we;
         waddr = host_addr;
         wdata = host_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   // The read samples the table before this edge's write, so it returns the old word.
   always_ff @(posedge clk) begin
      if (rst)
         dout <= '0;
      else
         dout <= mem[rd_addr];
   end

   // R7: a host write outside streaming mode lands at its address
   assert_host_write_R7 : assert property (@(posedge clk) disable iff (rst)
      (!stream_en && host_we) |=> mem[$past(host_addr)] == $past(host_wdata));

   // R5: a streaming write lands at the counter address
   assert_stream_write_R5 : assert property (@(posedge clk) disable iff (rst)
      stream_en |=> mem[$past(rd_addr)] == $past(stream_din));

endmodule

// File: rtl/cm_sequencer.sv
module cm_sequencer
   import cmseq_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 11,
   parameter int HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frame_p,
   input  logic [1:0]        mode,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] stream_din,
   output logic [DATA_W-1:0] dout
);

   cm_mode_e          mode_e;
   logic [ADDR_W-1:0] seq_addr;
   logic              stream_en;

   assign mode_e    = cm_mode_e'(mode);
   assign stream_en = mode_is_stream(mode_e);

   cm_addr_seq #(
      .ADDR_W   (ADDR_W),
      .HALF_DIV (HALF_DIV)
   ) u_seq (
      .clk     (clk),
      .rst     (rst),
      .frame_p (frame_p),
      .mode    (mode_e),
      .addr    (seq_addr)
   );

   cm_store #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_store (
      .clk        (clk),
      .rst        (rst),
      .stream_en  (stream_en),
      .rd_addr    (seq_addr),
      .stream_din (stream_din),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .dout       (dout)
   );

endmodule

// File: tb/cm_sequencer_tb.sv
`timescale 1ns/1ps
module cm_sequencer_tb;

   localparam int AW    = 11;
   localparam int DW    = 16;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst;
   logic          frame_p;
   logic [1:0]    mode;
   logic          host_we;
   logic [AW-1:0] host_addr;
   logic [DW-1:0] host_wdata;
   logic [DW-1:0] stream_din;
   logic [DW-1:0] dout;

   always #2 clk = ~clk;

   cm_sequencer u_dut (
      .clk        (clk),
      .rst        (rst),
      .frame_p    (frame_p),
      .mode       (mode),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .stream_din (stream_din),
      .dout       (dout)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string tag   = "R1";

   // Behavioural reference model: table contents, a known-flag per word,
   // the counter, the half-rate phase and the expected output.
   logic [DW-1:0] m [DEPTH];
   bit            v [DEPTH];
   int            ma  = 0;
   int            mph = 0;
   logic [DW-1:0] edout = '0;
   bit            ev = 1'b0;

   always @(posedge clk) begin
      if (rst) begin
         ma = 0; mph = 0; edout = '0; ev = 1'b1;
      end else begin
         edout = m[ma];
         ev    = v[ma];
         if (mode == 2'd2) begin
            m[ma] = stream_din; v[ma] = 1'b1;
         end else if (host_we) begin
            m[host_addr] = host_wdata; v[host_addr] = 1'b1;
         end
         if (frame_p) begin
            ma = 0; mph = 0;
         end else if (mode == 2'd0) begin
            if (mph == 1) ma = (ma + 1) % DEPTH;
            mph = 1 - mph;
         end else begin
            ma = (ma + 1) % DEPTH; mph = 0;
         end
      end
   end

   task automatic cyc();
      @(negedge clk);
      if (ev) begin
         n_cmp++;
         if (dout !== edout) begin
            n_bad++;
            $display("FAIL %s: dout=%h expected %h (t=%0t)", tag, dout, edout, $time);
         end
      end
   endtask

   task automatic pulse_frame();
      frame_p = 1'b1;
      cyc();
      frame_p = 1'b0;
   endtask

   initial begin : watchdog
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      rst = 1'b1; frame_p = 1'b0; mode = 2'd1; host_we = 1'b0;
      host_addr = '0; host_wdata = '0; stream_din = '0;

      // R1: output zero while held in reset
      tag = "R1";
      repeat (3) cyc();
      rst = 1'b0;

      // R7: load the whole table through the host port in full-rate mode
      tag = "R7";
      pulse_frame();
      for (int i = 0; i < DEPTH; i++) begin
         host_we    = 1'b1;
         host_addr  = AW'(i);
         host_wdata = DW'(i * 37 + 5) ^ 16'hA5C3;
         cyc();
      end
      host_we = 1'b0;

      // R3 / R11: one word per clock, across the 2047 -> 0 wrap
      tag = "R3/R11";
      repeat (2100) cyc();

      // R4: frame pulse mid-sequence in full-rate
      tag = "R4";
      repeat (500) cyc();
      pulse_frame();
      repeat (40) cyc();

      // R2: half-rate dwell; R4: frame pulse landing in the odd phase
      tag = "R2";
      mode = 2'd0;
      pulse_frame();
      repeat (301) cyc();
      tag = "R2/R4";
      pulse_frame();
      repeat (200) cyc();

      // R8: host write colliding with the read address returns old data
      tag = "R8";
      mode = 2'd1;
      pulse_frame();
      for (int i = 0; i < 200; i++) begin
         host_we    = 1'b1;
         host_addr  = AW'(ma);
         host_wdata = DW'(i * 911) ^ 16'h3C3C;
         cyc();
      end
      host_we = 1'b0;
      repeat (50) cyc();

      // R10: mode 3 sequences as full-rate
      tag = "R10";
      mode = 2'd3;
      repeat (300) cyc();

      // R5 / R9: streaming fill with host writes attempted
      tag = "R5/R9";
      mode = 2'd2;
      pulse_frame();
      for (int i = 0; i < DEPTH; i++) begin
         stream_din = DW'($urandom);
         host_we    = 1'($urandom);
         host_addr  = AW'($urandom);
         host_wdata = DW'($urandom);
         cyc();
      end

      // R6: output equals the input of one full counter cycle earlier
      tag = "R6";
      for (int i = 0; i < 2100; i++) begin
         stream_din = DW'($urandom);
         host_we    = 1'($urandom);
         host_addr  = AW'($urandom);
         cyc();
      end
      host_we = 1'b0;

      // R9: read the table back; any host write leaking in would show here
      tag = "R9";
      mode = 2'd1;
      pulse_frame();
      repeat (2100) cyc();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule